// File: doc/BRIEF.md
# Serial Display-Memory Write Decoder

This block sits behind the byte receiver of a two-wire or four-wire serial slave in an on-screen-display controller. Once the slave has been addressed, each received byte arrives with a one-cycle strobe. The decoder works out what each byte is for. A byte is either an address (high part, low part) or a data byte. Data bytes become single-cycle write strobes into one of two memory spaces. The first is the character-code and control-register space, addressed by row and column. The second is the downloadable glyph store, addressed by segment and line. A level input, `fontMode`, chooses which space the bytes decode into.

Three framings are supported:
- **Format (a):** every data byte is preceded by a full address.
- **Format (b):** the row is kept, and each data byte is preceded only by a new column.
- **Format (c):** one full address is followed by an unbroken run of data bytes, and the address advances by itself after each write.

Entering the streaming framing is one-way for the rest of the transfer. A start or stop condition on the bus is presented as a `frameReset` pulse. It returns the decoder to its idle expectation.

Write outputs are registered. A data byte accepted on a clock edge appears on the write port, with its address, in the following cycle.

Top module: `osd_wr_decoder`

## Requirements
- R1: After reset, and after a `frameReset` pulse, the decoder expects a row (or segment) address. Any other byte is ignored, with no write. A byte offered in the same cycle as `frameReset` is dropped, and the cycle after a `frameReset` carries no write.
- R2: With `fontMode`=0, a byte with bit 7 set is a row address, taken from bits 3:0. A byte with bit 7 clear is a column address, taken from bits 4:0. The byte after a column address is data, whatever its bits. One cycle after that data byte is accepted, `dispWe` pulses for one cycle, with `dispRow`/`dispCol` holding the address and `dispData` holding the byte.
- R3: After a data byte, a column byte with bit 6 clear keeps the current row and makes the next byte data for the new column (format b).
- R4: After a data byte, a row byte starts a fresh row-then-column address (format a).
- R5: A column byte with bit 6 set enters streaming. Every later byte is written, and the column then advances by one. After column 31 it wraps to 0 and the row advances by one.
- R6: While streaming, a byte with bit 7 set is written as data and is not taken as a row. Only `frameReset` leaves streaming.
- R7: A column byte with bit 6 set that directly follows a data byte (no fresh row) is ignored. The next byte is then still decoded as an address.
- R8: With `fontMode`=1, bits 7:6 = 11 mark a segment address (bits 3:0). Bits 7:6 = 00 mark a line address (bits 3:0) for formats a/b, and 01 mark a line address that enters streaming. A byte tagged 10 in an address slot is ignored.
- R9: Glyph data writes pulse `fontWe`, with `fontBits` equal to bits 4:0 of the data byte. Bits 7:5 have no effect.
- R10: In glyph streaming, the line advances after each write. After line 15 it wraps to 0 and the segment advances by one.
- R11: `dispWe` and `fontWe` never pulse together. Writes go only to the space selected by `fontMode` when the data byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fontMode | input | 1 | 0: row/column space, 1: segment/line glyph space |
| frameReset | input | 1 | Start/stop seen on the bus; returns decoder to idle |
| byteValid | input | 1 | One-cycle strobe for a received byte |
| byteData | input | 8 | Received byte |
| dispWe | output | 1 | Write strobe, row/column space |
| dispRow | output | 4 | Row of the write |
| dispCol | output | 5 | Column of the write |
| dispData | output | 8 | Byte written |
| fontWe | output | 1 | Write strobe, glyph space |
| fontSeg | output | 4 | Segment of the glyph write |
| fontLine | output | 4 | Line of the glyph write |
| fontBits | output | 5 | Dot bits written |

## Verification
The bench builds the decoder with its default parameters:
- 32 column positions
- 16 glyph lines
- 4-bit row and segment fields

With these values, a streamed run started at column 30, or at line 15, reaches the wrap and the high-address carry within two or three bytes. Both spaces are exercised in one transfer each. Each transfer walks through legal framing changes and an illegal change back into streaming. It also covers a tag-10 byte that must be skipped and a data byte whose top bit would otherwise read as an address.

// File: rtl/osd_wr_pkg.sv
package osd_wr_pkg;

  // Where the decoder is within a transfer.
  typedef enum logic [2:0] {
    ST_HI     = 3'd0,  // waiting for row / segment
    ST_LO     = 3'd1,  // high part known, waiting for column / line
    ST_INFO   = 3'd2,  // next byte is data
    ST_POST   = 3'd3,  // a data byte was just written (formats a/b)
    ST_STREAM = 3'd4   // locked into streaming until frame reset
  } decState_t;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic loadHi;   // capture row / segment
    logic loadLo;   // capture column / line
    logic write;    // emit a write with the current address
    logic advance;  // step the address after this write
    logic toFont;   // space the strobes apply to
  } decStrobe_t;

endpackage

// File: rtl/osd_wr_ctrl.sv
module osd_wr_ctrl
  import osd_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fontMode,
  input  logic       frameReset,
  input  logic       byteValid,
  input  logic [1:0] tagBits,   // the two most significant bits of the byte
  output decStrobe_t strb
);

  decState_t st, stNext;
  logic isHi, isLo, loStream;

  // Address-role classification; only meaningful in address slots.
  always_comb begin
    loStream = tagBits[0];
    isLo     = !tagBits[1];
    if (fontMode) isHi = tagBits[1] && tagBits[0];
    else          isHi = tagBits[1];
  end

  always_comb begin
    stNext = st;
    strb   = '0;
    strb.toFont = fontMode;
    if (frameReset) begin
      stNext = ST_HI;
    end else if (byteValid) begin
      case (st)
        ST_HI: begin
          if (isHi) begin
            strb.loadHi = 1'b1;
            stNext      = ST_LO;
          end
        end
        ST_LO: begin
          if (isHi) begin
            strb.loadHi = 1'b1;
          end else if (isLo) begin
            strb.loadLo = 1'b1;
            stNext      = loStream ? ST_STREAM : ST_INFO;
          end
        end
        ST_INFO: begin
          strb.write = 1'b1;
          stNext     = ST_POST;
        end
        ST_POST: begin
          if (isHi) begin
            strb.loadHi = 1'b1;
            stNext      = ST_LO;
          end else if (isLo && !loStream) begin
            strb.loadLo = 1'b1;
            stNext      = ST_INFO;
          end
        end
        ST_STREAM: begin
          strb.write   = 1'b1;
          strb.advance = 1'b1;
        end
        default: stNext = ST_HI;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_HI;
    else       st <= stNext;
  end

endmodule

// File: rtl/osd_wr_dpath.sv
module osd_wr_dpath
  import osd_wr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int HI_W       = 4,
  parameter int DISP_COLS  = 32,
  parameter int FONT_LINES = 16,
  parameter int FONT_DW    = 5,
  localparam int COL_W  = $clog2(DISP_COLS),
  localparam int LINE_W = $clog2(FONT_LINES),
  localparam int LO_W   = (COL_W > LINE_W) ? COL_W : LINE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  decStrobe_t        strb,
  input  logic [BYTE_W-1:0] byteData,
  output logic              dispWe,
  output logic [HI_W-1:0]   dispRow,
  output logic [COL_W-1:0]  dispCol,
  output logic [BYTE_W-1:0] dispData,
  output logic              fontWe,
  output logic [HI_W-1:0]   fontSeg,
  output logic [LINE_W-1:0] fontLine,
  output logic [FONT_DW-1:0] fontBits
);

  localparam logic [LO_W-1:0] DISP_LAST = LO_W'(DISP_COLS - 1);
  localparam logic [LO_W-1:0] FONT_LAST = LO_W'(FONT_LINES - 1);

  logic [HI_W-1:0] hiAddr;
  logic [LO_W-1:0] loAddr, loLoad, lastLo;

  always_comb begin
    if (strb.toFont) begin
      loLoad = LO_W'(byteData[LINE_W-1:0]);
      lastLo = FONT_LAST;
    end else begin
      loLoad = LO_W'(byteData[COL_W-1:0]);
      lastLo = DISP_LAST;
    end
  end

  // Address registers: loads from address bytes, stepping in streaming.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiAddr <= '0;
      loAddr <= '0;
    end else begin
      if (strb.loadHi) hiAddr <= byteData[HI_W-1:0];
      if (strb.loadLo) loAddr <= loLoad;
      if (strb.write && strb.advance) begin
        if (loAddr == lastLo) begin
          loAddr <= '0;
          hiAddr <= hiAddr + HI_W'(1);
        end else begin
          loAddr <= loAddr + LO_W'(1);
        end
      end
    end
  end

  // Registered write ports.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispWe   <= 1'b0;
      dispRow  <= '0;
      dispCol  <= '0;
      dispData <= '0;
      fontWe   <= 1'b0;
      fontSeg  <= '0;
      fontLine <= '0;
      fontBits <= '0;
    end else begin
      dispWe <= strb.write && !strb.toFont;
      fontWe <= strb.write && strb.toFont;
      if (strb.write && !strb.toFont) begin
        dispRow  <= hiAddr;
        dispCol  <= loAddr[COL_W-1:0];
        dispData <= byteData;
      end
      if (strb.write && strb.toFont) begin
        fontSeg  <= hiAddr;
        fontLine <= loAddr[LINE_W-1:0];
        fontBits <= byteData[FONT_DW-1:0];
      end
    end
  end

endmodule

// File: rtl/osd_wr_decoder.sv
module osd_wr_decoder
  import osd_wr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int HI_W       = 4,
  parameter int DISP_COLS  = 32,
  parameter int FONT_LINES = 16,
  parameter int FONT_DW    = 5,
  localparam int COL_W  = $clog2(DISP_COLS),
  localparam int LINE_W = $clog2(FONT_LINES)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fontMode,
  input  logic               frameReset,
  input  logic               byteValid,
  input  logic [BYTE_W-1:0]  byteData,
  output logic               dispWe,
  output logic [HI_W-1:0]    dispRow,
  output logic [COL_W-1:0]   dispCol,
  output logic [BYTE_W-1:0]  dispData,
  output logic               fontWe,
  output logic [HI_W-1:0]    fontSeg,
  output logic [LINE_W-1:0]  fontLine,
  output logic [FONT_DW-1:0] fontBits
);

  decStrobe_t strb;

  osd_wr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fontMode   (fontMode),
    .frameReset (frameReset),
    .byteValid  (byteValid),
    .tagBits    (byteData[BYTE_W-1 -: 2]),
    .strb       (strb)
  );

  osd_wr_dpath #(
    .BYTE_W     (BYTE_W),
    .HI_W       (HI_W),
    .DISP_COLS  (DISP_COLS),
    .FONT_LINES (FONT_LINES),
    .FONT_DW    (FONT_DW)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .byteData (byteData),
    .dispWe   (dispWe),
    .dispRow  (dispRow),
    .dispCol  (dispCol),
    .dispData (dispData),
    .fontWe   (fontWe),
    .fontSeg  (fontSeg),
    .fontLine (fontLine),
    .fontBits (fontBits)
  );

endmodule

// File: rtl/osd_wr_chk.sv
module osd_wr_chk #(
  parameter int BYTE_W     = 8,
  parameter int HI_W       = 4,
  parameter int DISP_COLS  = 32,
  parameter int FONT_LINES = 16,
  parameter int FONT_DW    = 5,
  localparam int COL_W  = $clog2(DISP_COLS),
  localparam int LINE_W = $clog2(FONT_LINES)
)(
  input logic               clk,
  input logic               rstN,
  input logic               fontMode,
  input logic               frameReset,
  input logic               byteValid,
  input logic [BYTE_W-1:0]  byteData,
  input logic               dispWe,
  input logic [HI_W-1:0]    dispRow,
  input logic [COL_W-1:0]   dispCol,
  input logic [BYTE_W-1:0]  dispData,
  input logic               fontWe,
  input logic [HI_W-1:0]    fontSeg,
  input logic [LINE_W-1:0]  fontLine,
  input logic [FONT_DW-1:0] fontBits
);

  // R11: one space per write
  p_one_space_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(dispWe && fontWe));

  // R11: display writes come from an accepted byte in display mode
  p_disp_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    dispWe |-> ($past(byteValid) && !$past(fontMode) && !$past(frameReset)));

  // R11: glyph writes come from an accepted byte in glyph mode
  p_font_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    fontWe |-> ($past(byteValid) && $past(fontMode) && !$past(frameReset)));

  // R2: written data is the byte accepted one cycle earlier
  p_disp_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    dispWe |-> (dispData == $past(byteData)));

  // R9: glyph data keeps only the low bits
  p_font_bits_r9: assert property (@(posedge clk) disable iff (!rstN)
    fontWe |-> (fontBits == $past(byteData[FONT_DW-1:0])));

  // R1: no write in the cycle after a frame reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    frameReset |=> (!dispWe && !fontWe));

  // R5: back-to-back display writes only happen while streaming, one step apart
  p_disp_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dispWe && $past(dispWe)) |->
      ((dispRow == $past(dispRow) && dispCol == COL_W'($past(dispCol) + COL_W'(1))) ||
       (dispCol == '0 && $past(dispCol) == COL_W'(DISP_COLS - 1) &&
        dispRow == HI_W'($past(dispRow) + HI_W'(1)))));

  // R10: back-to-back glyph writes step the line, carrying into the segment
  p_font_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fontWe && $past(fontWe)) |->
      ((fontSeg == $past(fontSeg) && fontLine == LINE_W'($past(fontLine) + LINE_W'(1))) ||
       (fontLine == '0 && $past(fontLine) == LINE_W'(FONT_LINES - 1) &&
        fontSeg == HI_W'($past(fontSeg) + HI_W'(1)))));

endmodule

bind osd_wr_decoder osd_wr_chk #(
  .BYTE_W     (BYTE_W),
  .HI_W       (HI_W),
  .DISP_COLS  (DISP_COLS),
  .FONT_LINES (FONT_LINES),
  .FONT_DW    (FONT_DW)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fontMode   (fontMode),
  .frameReset (frameReset),
  .byteValid  (byteValid),
  .byteData   (byteData),
  .dispWe     (dispWe),
  .dispRow    (dispRow),
  .dispCol    (dispCol),
  .dispData   (dispData),
  .fontWe     (fontWe),
  .fontSeg    (fontSeg),
  .fontLine   (fontLine),
  .fontBits   (fontBits)
);

// File: tb/tb_osd_wr_decoder.sv
module tb_osd_wr_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fontMode = 1'b0;
  logic       frameReset = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       dispWe, fontWe;
  logic [3:0] dispRow, fontSeg, fontLine;
  logic [4:0] dispCol, fontBits;
  logic [7:0] dispData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  osd_wr_decoder dut (
    .clk(clk), .rstN(rstN), .fontMode(fontMode), .frameReset(frameReset),
    .byteValid(byteValid), .byteData(byteData),
    .dispWe(dispWe), .dispRow(dispRow), .dispCol(dispCol), .dispData(dispData),
    .fontWe(fontWe), .fontSeg(fontSeg), .fontLine(fontLine), .fontBits(fontBits)
  );

  // kind: 0 none, 1 display write, 2 glyph write
  typedef struct packed {
    logic       fm;
    logic       fr;
    logic [7:0] b;
    logic [1:0] kind;
    logic [3:0] hi;
    logic [4:0] lo;
    logic [7:0] d;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 1'b1, 8'h00, 2'd0, 4'd0, 5'd0,  8'h00, 4'd1},  // R1 frame reset
    '{1'b0, 1'b0, 8'h05, 2'd0, 4'd0, 5'd0,  8'h00, 4'd1},  // R1 column before row: ignored
    '{1'b0, 1'b0, 8'h83, 2'd0, 4'd0, 5'd0,  8'h00, 4'd2},  // R2 row 3
    '{1'b0, 1'b0, 8'h07, 2'd0, 4'd0, 5'd0,  8'h00, 4'd2},  // R2 column 7
    '{1'b0, 1'b0, 8'h41, 2'd1, 4'd3, 5'd7,  8'h41, 4'd2},  // R2 data
    '{1'b0, 1'b0, 8'h0A, 2'd0, 4'd0, 5'd0,  8'h00, 4'd3},  // R3 column 10 only
    '{1'b0, 1'b0, 8'h9C, 2'd1, 4'd3, 5'd10, 8'h9C, 4'd3},  // R3 data with top bit set
    '{1'b0, 1'b0, 8'h4B, 2'd0, 4'd0, 5'd0,  8'h00, 4'd7},  // R7 stream column after data: ignored
    '{1'b0, 1'b0, 8'h0C, 2'd0, 4'd0, 5'd0,  8'h00, 4'd7},  // R7 still an address slot
    '{1'b0, 1'b0, 8'h11, 2'd1, 4'd3, 5'd12, 8'h11, 4'd7},  // R7 data at column 12
    '{1'b0, 1'b0, 8'h85, 2'd0, 4'd0, 5'd0,  8'h00, 4'd4},  // R4 fresh row 5
    '{1'b0, 1'b0, 8'h5E, 2'd0, 4'd0, 5'd0,  8'h00, 4'd5},  // R5 stream column 30
    '{1'b0, 1'b0, 8'hAA, 2'd1, 4'd5, 5'd30, 8'hAA, 4'd5},  // R5 first streamed
    '{1'b0, 1'b0, 8'h86, 2'd1, 4'd5, 5'd31, 8'h86, 4'd6},  // R6 row-tagged byte is data
    '{1'b0, 1'b0, 8'h01, 2'd1, 4'd6, 5'd0,  8'h01, 4'd5},  // R5 wrap to column 0, row 6
    '{1'b0, 1'b1, 8'h00, 2'd0, 4'd0, 5'd0,  8'h00, 4'd6},  // R6 frame reset leaves stream
    '{1'b0, 1'b0, 8'h02, 2'd0, 4'd0, 5'd0,  8'h00, 4'd6},  // R6 no longer streaming
    '{1'b1, 1'b1, 8'h00, 2'd0, 4'd0, 5'd0,  8'h00, 4'd1},  // R1 frame reset, glyph space
    '{1'b1, 1'b0, 8'hC2, 2'd0, 4'd0, 5'd0,  8'h00, 4'd8},  // R8 segment 2
    '{1'b1, 1'b0, 8'h03, 2'd0, 4'd0, 5'd0,  8'h00, 4'd8},  // R8 line 3
    '{1'b1, 1'b0, 8'hFF, 2'd2, 4'd2, 5'd3,  8'h1F, 4'd9},  // R9 upper bits dropped
    '{1'b1, 1'b0, 8'h85, 2'd0, 4'd0, 5'd0,  8'h00, 4'd8},  // R8 tag 10 ignored
    '{1'b1, 1'b0, 8'h05, 2'd0, 4'd0, 5'd0,  8'h00, 4'd8},  // R8 line 5
    '{1'b1, 1'b0, 8'hE6, 2'd2, 4'd2, 5'd5,  8'h06, 4'd9},  // R9 data
    '{1'b1, 1'b0, 8'hC7, 2'd0, 4'd0, 5'd0,  8'h00, 4'd8},  // R8 segment 7
    '{1'b1, 1'b0, 8'h4F, 2'd0, 4'd0, 5'd0,  8'h00, 4'd10}, // R10 stream line 15
    '{1'b1, 1'b0, 8'h12, 2'd2, 4'd7, 5'd15, 8'h12, 4'd10}, // R10 first streamed
    '{1'b1, 1'b0, 8'hC0, 2'd2, 4'd8, 5'd0,  8'h00, 4'd10}, // R10 wrap, segment 8
    '{1'b0, 1'b1, 8'h00, 2'd0, 4'd0, 5'd0,  8'h00, 4'd11}  // R11 back to display, quiet
  };

  function automatic logic [18:0] observed();
    logic [18:0] r;
    r = '0;
    r[18] = fontWe;
    r[17] = dispWe;
    if (dispWe) r[16:0] = {dispRow, dispCol, dispData};
    if (fontWe) r[16:0] = {fontSeg, 1'b0, fontLine, 3'b000, fontBits};
    return r;
  endfunction

  task automatic check(input logic [18:0] act, input logic [18:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic push(input logic fm, input logic fr, input logic [7:0] b);
    fontMode   = fm;
    frameReset = fr;
    byteValid  = !fr;
    byteData   = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(observed(), 19'd0, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(observed(), 19'd0, 1);

    for (int i = 0; i < NV; i++) begin
      push(VECS[i].fm, VECS[i].fr, VECS[i].b);
      check(observed(), {VECS[i].kind[1], VECS[i].kind[0], VECS[i].hi, VECS[i].lo, VECS[i].d},
            int'(VECS[i].req));
    end

    // R1 byte alongside frame reset is dropped, next non-row ignored
    push(1'b0, 1'b0, 8'h81);
    push(1'b0, 1'b0, 8'h02);
    fontMode = 1'b0; frameReset = 1'b1; byteValid = 1'b1; byteData = 8'h33;
    @(negedge clk);
    check(observed(), 19'd0, 1);
    push(1'b0, 1'b0, 8'h44);
    check(observed(), 19'd0, 1);
    push(1'b0, 1'b0, 8'h82);
    push(1'b0, 1'b0, 8'h01);
    push(1'b0, 1'b0, 8'h55);
    check(observed(), {2'b01, 4'd2, 5'd1, 8'h55}, 1);

    // R1 hardware reset mid-stream restores idle
    push(1'b0, 1'b0, 8'h80);
    push(1'b0, 1'b0, 8'h40);
    push(1'b0, 1'b0, 8'h77);
    check(observed(), {2'b01, 4'd0, 5'd0, 8'h77}, 5);
    byteValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(observed(), 19'd0, 1);
    rstN = 1'b1;
    push(1'b0, 1'b0, 8'h66);
    check(observed(), 19'd0, 1);
    byteValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule